// File: doc/BRIEF.md
# Mode-Selectable 16-bit Timer/Event Counter

This block is a 16-bit up-counter that advances by one on each cycle where a count-enable strobe is high. It has two compare registers, an event input with a selectable active edge, one output line that inverts on chosen events, a one-cycle interrupt request, and a sticky overflow flag. A 3-bit mode code in the control register selects the behaviour. The counter can be stopped. It can run freely. It can clear and restart on each valid event edge. It can clear and restart when it matches the first compare value. The lowest mode bit also lets the event edge invert the output.

Software reaches the block through a small write/read port. The port has four word addresses: control, compare A, compare B and the live count. Compare values can be written at any time. The mode code can only be moved away from stopped while the timer is stopped, so a running timer must first be written to mode 000 before it is given a new mode.

Top module: `evt_timer16`

## Requirements
- R1: After reset the count, both compare registers, the control register, the output and the interrupt request all read 0.
- R2: In modes 000 and 001 the count is held at 0. Strobes, matches and event edges neither invert the output nor raise the interrupt request.
- R3: In mode 010 each strobe cycle adds one to the count. The count holds when the strobe is low, and it goes from FFFFH to 0000H on the strobe after FFFFH.
- R4: In a running mode (010 to 111), a strobe cycle whose count equals compare A or compare B inverts the output and raises the interrupt request for exactly the following cycle. Both changes are visible one cycle after that strobe.
- R5: In modes 011, 101 and 111 a valid event edge also inverts the output. In modes 010, 100 and 110 event edges leave the output unchanged.
- R6: In modes 100 and 101 a valid event edge clears the count to 0. The event input passes two synchronizer flops, so the count reads 0 at most four cycles after the input changes.
- R7: In modes 110 and 111 a strobe cycle whose count equals compare A sets the next count to 0 instead of adding one.
- R8: The overflow flag (control bit 7) sets when a strobe moves the count from FFFFH to 0000H. This happens in mode 010 for any compare A, and in modes 100 to 111 only when compare A holds FFFFH. The flag stays set until a control write carries 0 in bit 7. A write of bit 7 takes effect at any time.
- R9: While running, a control write whose mode field (bits 2:0) is not 000 leaves the mode and edge select unchanged. A write of 000 is always accepted and stops the counter, which then reads 0.
- R10: Edge select (control bits 5:4) decodes as follows: 00 means falling edge, 01 means rising edge, 10 or 11 means both edges.
- R11: Address 0 is control, address 1 is compare A and address 2 is compare B, all readable and writable. Address 3 reads the count, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-enable strobe |
| evt_in | input | 1 | Asynchronous event input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| tmr_out | output | 1 | Toggle output |
| irq | output | 1 | Interrupt request pulse |

## Verification
The checker assumes the count-enable strobe and the register port are driven synchronously and stay stable around the clock edge. It also assumes the event input holds each level long enough to pass the synchronizer. The clear and hold properties further assume that the event input does not produce a valid edge in a cycle the property treats as edge-free. The bench drives every input at the falling clock edge, holds each event level for four cycles, and keeps the strobe low during register access and event pulses. Under that stimulus each effect is tied to exactly one cause.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_CMP_A = 2'd1;
  localparam logic [1:0] ADDR_CMP_B = 2'd2;
  localparam logic [1:0] ADDR_COUNT = 2'd3;

  typedef enum logic [1:0] {
    EDGE_FALL  = 2'b00,
    EDGE_RISE  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTHX = 2'b11
  } edge_sel_e;

  // counter advances or responds to events only outside 00x
  function automatic logic mode_running(input logic [2:0] m);
    return m[2:1] != 2'b00;
  endfunction

  function automatic logic mode_edge_clear(input logic [2:0] m);
    return m[2:1] == 2'b10;
  endfunction

  function automatic logic mode_match_clear(input logic [2:0] m);
    return m[2:1] == 2'b11;
  endfunction

  function automatic logic mode_edge_toggle(input logic [2:0] m);
    return mode_running(m) && m[0];
  endfunction

  // wrap counts as overflow in free-run, or in clear modes when compare A is all ones
  function automatic logic mode_ovf_allowed(input logic [2:0] m, input logic cmp_a_full);
    return (m[2:1] == 2'b01) || (m[2] && cmp_a_full);
  endfunction

  function automatic logic edge_hit(input logic [1:0] sel, input logic cur, input logic prev);
    logic hit;
    if (sel[1])      hit = cur ^ prev;
    else if (sel[0]) hit = cur & ~prev;
    else             hit = ~cur & prev;
    return hit;
  endfunction

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge
  import evt_timer16_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_in,
  input  logic [1:0] edge_sel,
  output logic       evt_valid
);

  // STAGES synchronizer flops followed by one history flop
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], evt_in};
  end

  assign evt_valid = edge_hit(edge_sel, chain[STAGES-1], chain[STAGES]);

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import evt_timer16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  input  logic         ovf_set,
  input  logic [W-1:0] count,
  output logic [2:0]   mode,
  output logic [1:0]   edge_sel,
  output logic [W-1:0] cmp_a,
  output logic [W-1:0] cmp_b,
  output logic         ovf_flag,
  output logic [W-1:0] reg_rdata
);

  localparam int PAD = W - 8;

  logic ctrl_wr, mode_accept;

  assign ctrl_wr     = reg_wr && (reg_addr == ADDR_CTRL);
  assign mode_accept = !mode_running(mode) || (reg_wdata[2:0] == 3'b000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= 3'b000;
      edge_sel <= EDGE_FALL;
      cmp_a    <= '0;
      cmp_b    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ovf_flag <= reg_wdata[7];
        if (mode_accept) begin
          mode     <= reg_wdata[2:0];
          edge_sel <= reg_wdata[5:4];
        end
      end
      if (reg_wr && reg_addr == ADDR_CMP_A) cmp_a <= reg_wdata;
      if (reg_wr && reg_addr == ADDR_CMP_B) cmp_b <= reg_wdata;
      if (ovf_set) ovf_flag <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:  reg_rdata = {{PAD{1'b0}}, ovf_flag, 1'b0, edge_sel, 1'b0, mode};
      ADDR_CMP_A: reg_rdata = cmp_a;
      ADDR_CMP_B: reg_rdata = cmp_b;
      default:    reg_rdata = count;
    endcase
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import evt_timer16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         evt_valid,
  input  logic [2:0]   mode,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] count,
  output logic         match_a,
  output logic         match_b,
  output logic         edge_clear,
  output logic         ovf_set,
  output logic         tmr_out,
  output logic         irq
);

  logic running, at_top, toggle;
  logic [W-1:0] count_nx;

  assign running    = mode_running(mode);
  assign match_a    = running && cnt_en && (count == cmp_a);
  assign match_b    = running && cnt_en && (count == cmp_b);
  assign edge_clear = mode_edge_clear(mode) && evt_valid;
  assign at_top     = &count;
  assign ovf_set    = running && cnt_en && at_top && !edge_clear
                      && mode_ovf_allowed(mode, &cmp_a);
  assign toggle     = match_a || match_b || (mode_edge_toggle(mode) && evt_valid);

  always_comb begin
    if (!running)                             count_nx = '0;
    else if (edge_clear)                      count_nx = '0;
    else if (match_a && mode_match_clear(mode)) count_nx = '0;
    else if (cnt_en)                          count_nx = count + 1'b1;
    else                                      count_nx = count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      tmr_out <= 1'b0;
      irq     <= 1'b0;
    end else begin
      count   <= count_nx;
      tmr_out <= tmr_out ^ toggle;
      irq     <= match_a || match_b;
    end
  end

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer16_pkg::*;
#(
  parameter int W        = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         evt_in,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         tmr_out,
  output logic         irq
);

  logic [2:0]   mode;
  logic [1:0]   edge_sel;
  logic [W-1:0] cmp_a, cmp_b, count;
  logic         ovf_flag, ovf_set, evt_valid;
  logic         match_a, match_b, edge_clear;

  evt_sync_edge #(.STAGES(SYNC_LEN)) u_edge (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
    .edge_sel(edge_sel), .evt_valid(evt_valid)
  );

  tmr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ovf_set(ovf_set), .count(count),
    .mode(mode), .edge_sel(edge_sel), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .ovf_flag(ovf_flag), .reg_rdata(reg_rdata)
  );

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .evt_valid(evt_valid),
    .mode(mode), .cmp_a(cmp_a), .cmp_b(cmp_b), .count(count),
    .match_a(match_a), .match_b(match_b), .edge_clear(edge_clear),
    .ovf_set(ovf_set), .tmr_out(tmr_out), .irq(irq)
  );

endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [2:0]   mode,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_a,
  input logic [W-1:0] cmp_b,
  input logic         ovf_flag,
  input logic         evt_valid,
  input logic         tmr_out,
  input logic         irq
);

  logic stopped, ctrl_wr;
  assign stopped = (mode[2:1] == 2'b00);
  assign ctrl_wr = reg_wr && (reg_addr == 2'd0);

  assert_stop_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> (count == '0));

  assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !evt_valid) |=> (!irq && $stable(tmr_out)));

  assert_free_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b010 && cnt_en) |=> (count == $past(count) + 1'b1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && !cnt_en && !(mode[2:1] == 2'b10 && evt_valid)) |=> $stable(count));

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(cnt_en) && ($past(count) == $past(cmp_a) || $past(count) == $past(cmp_b))));

  assert_edge_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b10 && evt_valid) |=> (count == '0));

  assert_match_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b11 && cnt_en && count == cmp_a) |=> (count == '0));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(ctrl_wr && !reg_wdata[7])) |=> ovf_flag);

  assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (($past(cnt_en) && $past(&count)) || $past(ctrl_wr && reg_wdata[7])));

  assert_mode_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && ctrl_wr && reg_wdata[2:0] != 3'b000) |=> $stable(mode));

endmodule

bind evt_timer16 evt_timer16_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mode(mode), .count(count),
  .cmp_a(cmp_a), .cmp_b(cmp_b), .ovf_flag(ovf_flag), .evt_valid(evt_valid),
  .tmr_out(tmr_out), .irq(irq)
);

// File: tb/sim_evt_timer16.sv
`timescale 1ns/1ps
module sim_evt_timer16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        evt_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        tmr_out, irq;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  evt_timer16 u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .evt_in(evt_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tmr_out(tmr_out), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic strobe(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic set_evt(input logic v);
    @(negedge clk);
    evt_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1", "register after reset", d, 16'h0);
    end
    check("R1", "output after reset", {15'h0, tmr_out}, 16'h0);
    check("R1", "irq after reset", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    wr(2'd1, 16'hA5C3); rd(2'd1, d); check("R11", "compare A readback", d, 16'hA5C3);
    wr(2'd2, 16'h3C5A); rd(2'd2, d); check("R11", "compare B readback", d, 16'h3C5A);
    wr(2'd3, 16'h7777); rd(2'd3, d); check("R11", "count write ignored", d, 16'h0);
    wr(2'd0, 16'h0031); rd(2'd0, d); check("R11", "control readback", d, 16'h0031);
  endtask

  task automatic t_stop;
    logic [15:0] d;
    wr(2'd0, 16'h0010); wr(2'd1, 16'h0000); wr(2'd2, 16'h0000);
    strobe(3);
    check("R2", "irq in stop", {15'h0, irq}, 16'h0);
    check("R2", "output in stop", {15'h0, tmr_out}, 16'h0);
    rd(2'd3, d); check("R2", "count in stop", d, 16'h0);
    set_evt(1'b1); set_evt(1'b0);
    check("R2", "edge ignored in stop", {15'h0, tmr_out}, 16'h0);
    wr(2'd0, 16'h0001);
    strobe(3);
    rd(2'd3, d); check("R2", "count in mode 001", d, 16'h0);
    check("R2", "output in mode 001", {15'h0, tmr_out}, 16'h0);
  endtask

  task automatic t_freerun;
    logic [15:0] d;
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0003); wr(2'd2, 16'h0006);
    wr(2'd0, 16'h0012);
    strobe(3);
    rd(2'd3, d); check("R3", "count after 3 strobes", d, 16'h3);
    check("R4", "no toggle before match", {15'h0, tmr_out}, 16'h0);
    strobe(1);
    check("R4", "toggle on match A", {15'h0, tmr_out}, 16'h1);
    check("R4", "irq on match A", {15'h0, irq}, 16'h1);
    @(negedge clk);
    check("R4", "irq one cycle", {15'h0, irq}, 16'h0);
    repeat (3) @(negedge clk);
    rd(2'd3, d); check("R3", "count holds without strobe", d, 16'h4);
    strobe(2); strobe(1);
    check("R4", "toggle on match B", {15'h0, tmr_out}, 16'h0);
    check("R4", "irq on match B", {15'h0, irq}, 16'h1);
    set_evt(1'b1);
    check("R5", "edge ignored in mode 010", {15'h0, tmr_out}, 16'h0);
    set_evt(1'b0);
  endtask

  task automatic t_gate;
    logic [15:0] d;
    wr(2'd0, 16'h0006);
    rd(2'd0, d); check("R9", "running mode write ignored", d, 16'h0012);
    rd(2'd3, d); check("R9", "count kept after ignored write", d, 16'h7);
    wr(2'd0, 16'h0030);
    rd(2'd0, d); check("R9", "stop write accepted", d, 16'h0030);
    rd(2'd3, d); check("R9", "count zero after stop", d, 16'h0);
  endtask

  task automatic t_edge_sel;
    logic o;
    wr(2'd0, 16'h0013);
    o = tmr_out;
    set_evt(1'b1); check("R10", "rise toggles, sel 01", {15'h0, tmr_out}, {15'h0, ~o});
    set_evt(1'b0); check("R10", "fall ignored, sel 01", {15'h0, tmr_out}, {15'h0, ~o});
    wr(2'd0, 16'h0000); wr(2'd0, 16'h0003);
    o = tmr_out;
    set_evt(1'b1); check("R10", "rise ignored, sel 00", {15'h0, tmr_out}, {15'h0, o});
    set_evt(1'b0); check("R5", "fall toggles, sel 00", {15'h0, tmr_out}, {15'h0, ~o});
    wr(2'd0, 16'h0000); wr(2'd0, 16'h0023);
    o = tmr_out;
    set_evt(1'b1); check("R10", "rise toggles, sel 10", {15'h0, tmr_out}, {15'h0, ~o});
    set_evt(1'b0); check("R10", "fall toggles, sel 10", {15'h0, tmr_out}, {15'h0, o});
  endtask

  task automatic t_edge_clear;
    logic [15:0] d;
    logic o;
    wr(2'd0, 16'h0000); wr(2'd0, 16'h0014);
    strobe(10);
    rd(2'd3, d); check("R6", "count before edge", d, 16'd10);
    o = tmr_out;
    set_evt(1'b1);
    rd(2'd3, d); check("R6", "edge clears count, mode 100", d, 16'h0);
    check("R5", "edge no toggle, mode 100", {15'h0, tmr_out}, {15'h0, o});
    set_evt(1'b0);
    wr(2'd0, 16'h0000); wr(2'd0, 16'h0015);
    strobe(2);
    o = tmr_out;
    set_evt(1'b1);
    rd(2'd3, d); check("R6", "edge clears count, mode 101", d, 16'h0);
    check("R5", "edge toggles, mode 101", {15'h0, tmr_out}, {15'h0, ~o});
    set_evt(1'b0);
  endtask

  task automatic t_match_clear;
    logic [15:0] d;
    logic o;
    wr(2'd0, 16'h0000); wr(2'd0, 16'h0016);
    strobe(4);
    check("R7", "irq at match A, mode 110", {15'h0, irq}, 16'h1);
    rd(2'd3, d); check("R7", "match A clears count", d, 16'h0);
    strobe(2);
    rd(2'd3, d); check("R7", "restart after clear", d, 16'h2);
    o = tmr_out;
    set_evt(1'b1);
    check("R5", "edge no toggle, mode 110", {15'h0, tmr_out}, {15'h0, o});
    set_evt(1'b0);
    wr(2'd0, 16'h0000); wr(2'd0, 16'h0017);
    o = tmr_out;
    set_evt(1'b1);
    check("R5", "edge toggles, mode 111", {15'h0, tmr_out}, {15'h0, ~o});
    set_evt(1'b0);
  endtask

  task automatic t_overflow;
    logic [15:0] d;
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h1234);
    wr(2'd0, 16'h0002);
    strobe(65535);
    rd(2'd3, d); check("R3", "count at top", d, 16'hFFFF);
    rd(2'd0, d); check("R8", "no overflow before wrap", {15'h0, d[7]}, 16'h0);
    strobe(1);
    rd(2'd3, d); check("R3", "wrap to zero", d, 16'h0);
    rd(2'd0, d); check("R8", "overflow set in free run", {15'h0, d[7]}, 16'h1);
    strobe(5);
    rd(2'd0, d); check("R8", "overflow sticky", {15'h0, d[7]}, 16'h1);
    wr(2'd0, 16'h0002);
    rd(2'd0, d); check("R8", "overflow cleared by write", d, 16'h0002);
    wr(2'd0, 16'h0000); wr(2'd0, 16'h0004);
    strobe(65536);
    rd(2'd3, d); check("R8", "mode 100 wraps", d, 16'h0);
    rd(2'd0, d); check("R8", "no overflow mode 100, compare A not top", {15'h0, d[7]}, 16'h0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not finish (got hang, expected finish)");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_stop();
    t_freerun();
    t_gate();
    t_edge_sel();
    t_edge_clear();
    t_match_clear();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule